// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a reference-style page table held in memory. A walk starts at a per-context entry. It then descends through up to three further levels of table. At each level it reads one 32-bit word over a simple memory port. The walk may stop at the first, second or third level on a leaf entry, giving a 16 MB, 256 KB or 4 KB page.

For a leaf, the walker checks the request's access kind and privilege against the leaf's 3-bit access field. It sets the referenced and modified flags and writes the entry back when they change. It then answers with the physical address, the page size and the granted rights. On any failure it answers with a fault code that carries the level and the kind of failure. It also loads a sticky fault status word and a fault address word. The status word records overflow when a second fault lands before software has read the first.

A bypass input skips translation. In boot mode, fetches issued with bypass are steered into a ROM window. A no-fault control lets user-mode permission failures through silently.

Top module: `pgwalk_top`

## Requirements
- R1: A table walk starts with a read at address (ctx_ptr << 4) + (ctx_num << 2), on the 36-bit memory address bus.
- R2: Bits [1:0] of every table word give its kind: 0 invalid, 1 pointer, 2 leaf, 3 reserved. After a pointer word, the next read goes to ({word[31:2], 2'b00} << 4) plus 4 times an index. The index is VA[31:24] after the context entry, VA[23:18] after the first level and VA[17:12] after the second.
- R3: A leaf answers with rsp_paddr = ({word[31:8]} << 12) plus the in-page offset: VA[23:0] at level 1, VA[17:0] at level 2 and VA[11:0] at level 3. rsp_size is 2, 1 or 0 respectively.
- R4: rsp_fcode holds a level (0 to 3) in bits [9:8] and a type in bits [4:2]. A table fault uses type 1 for an invalid word. It uses type 4 for a memory error, a reserved word, a leaf at the context level or a pointer at level 3. A permission fault carries level 0 with type 2 (protection) or type 3 (privilege).
- R5: Access kind (req_kind 0 read, 1 write, 2 fetch) and req_super are checked against the leaf's access field word[4:2]. For user mode, fields 6 and 7 give a privilege fault. Otherwise a read faults only on field 4. A fetch faults on fields 0, 1 and 5. A write is allowed on fields 1 and 3, and also on 5 and 7 in supervisor mode.
- R6: On a granted access, the referenced flag (word bit 5) is set. On a write, the modified flag (bit 6) is also set. The word is written back to the same address only if one of them was clear.
- R7: rsp_perm is {read, write, execute}. It grants write only when the updated leaf has its modified flag set.
- R8: On a fault, the status word is first set to 1 if it was nonzero. It is then OR-ed with {write, fetch, super} << 5, the fault code and 2. far_q takes the faulting virtual address.
- R9: A one-cycle pulse on fsr_rd clears the status word to zero.
- R10: With nofault set, a user-mode permission failure still yields a translation with the leaf's rights and leaves the status word untouched. A supervisor permission failure still faults.
- R11: With req_bypass set, the answer comes without memory reads, as a 4 KB page. A fetch in boot mode maps to prom_base | VA[18:0] with read and execute rights. Any other bypassed access maps to VA with all rights.
- R12: req_ready is high only when idle. Each memory request keeps its address and direction until mem_ack. rsp_valid lasts one cycle, after which the walker is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a translation |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_super | input | 1 | Supervisor privilege |
| req_bypass | input | 1 | Skip translation |
| rsp_valid | output | 1 | Result valid for one cycle |
| rsp_fault | output | 1 | Result is a fault |
| rsp_paddr | output | 36 | Physical address |
| rsp_size | output | 2 | 0 4 KB, 1 256 KB, 2 16 MB |
| rsp_perm | output | 3 | Rights {read, write, execute} |
| rsp_fcode | output | 10 | Level and type of fault |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 36 | Byte address of table word |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Access failed, with mem_ack |
| mem_rdata | input | 32 | Read data, with mem_ack |
| ctx_ptr | input | 32 | Context table pointer |
| ctx_num | input | CTX_W | Context number |
| nofault | input | 1 | Let user permission failures pass |
| bootmode | input | 1 | Steer bypassed fetches to ROM |
| prom_base | input | 36 | ROM window base |
| fsr_rd | input | 1 | Read-and-clear strobe for status |
| fsr_q | output | 32 | Fault status word |
| far_q | output | 32 | Fault address |

## Verification
The bench builds the walker with its default CTX_W of 8. This lets it pick two distinct contexts whose entries sit in one small table: one that leads into a full table tree, and one whose entry is a stray leaf. Its memory model stores words sparsely at 36-bit addresses and can force an error at one chosen address. This makes leaves at all three levels, faults at every level and write-backs observable from the port side.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int VA_W  = 32;
  localparam int PA_W  = 36;
  localparam int ENT_W = 32;
  localparam int FC_W  = 10;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } kind_e;

  localparam logic [1:0] ET_INVALID = 2'd0;
  localparam logic [1:0] ET_PTR     = 2'd1;
  localparam logic [1:0] ET_LEAF    = 2'd2;
  localparam logic [1:0] ET_RSVD    = 2'd3;

  localparam logic [2:0] FT_NONE    = 3'd0;
  localparam logic [2:0] FT_INVALID = 3'd1;
  localparam logic [2:0] FT_PROT    = 3'd2;
  localparam logic [2:0] FT_PRIV    = 3'd3;
  localparam logic [2:0] FT_XLATE   = 3'd4;

  localparam int BIT_REF = 5;
  localparam int BIT_MOD = 6;

  function automatic logic [FC_W-1:0] mk_code(input logic [1:0] lvl, input logic [2:0] ft);
    return {lvl, 3'b000, ft, 2'b00};
  endfunction
endpackage

// File: rtl/pgwalk_rights.sv
module pgwalk_rights
  import pgwalk_pkg::*;
(
  input  kind_e      kind,
  input  logic       sup,
  input  logic [2:0] acc,
  output logic [2:0] ftype,
  output logic [2:0] rights
);
  // rights bit order: {read, write, execute}
  always_comb begin
    ftype = FT_NONE;
    if (!sup && acc[2:1] == 2'b11) begin
      ftype = FT_PRIV;
    end else begin
      unique case (kind)
        KIND_WRITE: begin
          if (acc == 3'd0 || acc == 3'd2 || acc == 3'd4) ftype = FT_PROT;
          else if (acc == 3'd5 && !sup) ftype = FT_PROT;
          else if (acc == 3'd6 && sup)  ftype = FT_PROT;
        end
        KIND_FETCH: begin
          if (acc == 3'd0 || acc == 3'd1 || acc == 3'd5) ftype = FT_PROT;
        end
        default: begin
          if (acc == 3'd4) ftype = FT_PROT;
        end
      endcase
    end
  end

  always_comb begin
    unique case (acc)
      3'd0: rights = 3'b100;
      3'd1: rights = 3'b110;
      3'd2: rights = 3'b101;
      3'd3: rights = 3'b111;
      3'd4: rights = 3'b001;
      3'd5: rights = sup ? 3'b110 : 3'b100;
      3'd6: rights = sup ? 3'b101 : 3'b000;
      default: rights = sup ? 3'b111 : 3'b000;
    endcase
  end
endmodule

// File: rtl/pgwalk_fsr.sv
module pgwalk_fsr
  import pgwalk_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            evt,
  input  logic [FC_W-1:0] code,
  input  logic [2:0]      aidx,
  input  logic [VA_W-1:0] va,
  input  logic            rd,
  output logic [31:0]     fsr_q,
  output logic [31:0]     far_q
);
  logic [31:0] base;
  assign base = (fsr_q != 32'd0) ? 32'd1 : 32'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      fsr_q <= '0;
      far_q <= '0;
    end else if (evt) begin
      fsr_q <= base | ({29'd0, aidx} << 5) | {{(32-FC_W){1'b0}}, code} | 32'd2;
      far_q <= va;
    end else if (rd) begin
      fsr_q <= '0;
    end
  end

  p_valid_after_fault_r8: assert property (@(posedge clk) disable iff (rst)
    evt |=> fsr_q[1]);
  p_overflow_mark_r8: assert property (@(posedge clk) disable iff (rst)
    (evt && fsr_q != 32'd0) |=> fsr_q[0]);
  p_read_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (rd && !evt) |=> fsr_q == 32'd0);
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic             req_super,
  input  logic             req_bypass,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [35:0]      rsp_paddr,
  output logic [1:0]       rsp_size,
  output logic [2:0]       rsp_perm,
  output logic [9:0]       rsp_fcode,
  output logic             mem_req,
  output logic             mem_we,
  output logic [35:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic             mem_err,
  input  logic [31:0]      mem_rdata,
  input  logic [31:0]      ctx_ptr,
  input  logic [CTX_W-1:0] ctx_num,
  input  logic             nofault,
  input  logic             bootmode,
  input  logic [35:0]      prom_base,
  input  logic             fsr_rd,
  output logic [31:0]      fsr_q,
  output logic [31:0]      far_q
);
  localparam int ROM_OFS_W = 19;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WB, S_RSP} st_e;

  st_e             st;
  logic [1:0]      lvl;
  logic [VA_W-1:0] va;
  kind_e           kind;
  logic            sup;

  logic [2:0]      aidx;
  logic [2:0]      p_ftype, p_rights;
  logic [PA_W-1:0] ctx_addr, idx4, nxt_ptr, pg_off, leaf_pa;
  logic [ENT_W-1:0] upd;
  logic            d_fault, d_ptr, d_leaf;
  logic [FC_W-1:0] d_code;
  logic [2:0]      fin_rights;

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_RSP);
  assign mem_req   = (st == S_RD) || (st == S_WB);
  assign aidx      = {kind == KIND_WRITE, kind == KIND_FETCH, sup};

  assign ctx_addr = {ctx_ptr, 4'b0000} + ({{(PA_W-CTX_W){1'b0}}, ctx_num} << 2);

  pgwalk_rights u_rights (
    .kind   (kind),
    .sup    (sup),
    .acc    (mem_rdata[4:2]),
    .ftype  (p_ftype),
    .rights (p_rights)
  );

  always_comb begin
    unique case (lvl)
      2'd0:    idx4 = {26'd0, va[31:24], 2'b00};
      2'd1:    idx4 = {28'd0, va[23:18], 2'b00};
      default: idx4 = {28'd0, va[17:12], 2'b00};
    endcase
    unique case (lvl)
      2'd1:    pg_off = {12'd0, va[23:0]};
      2'd2:    pg_off = {18'd0, va[17:0]};
      default: pg_off = {24'd0, va[11:0]};
    endcase
  end

  assign nxt_ptr = {mem_rdata[31:2], 6'b000000} + idx4;
  assign leaf_pa = {mem_rdata[31:8], 12'h000} + pg_off;
  assign upd     = mem_rdata | (32'd1 << BIT_REF) | ((kind == KIND_WRITE) ? (32'd1 << BIT_MOD) : 32'd0);
  assign fin_rights = p_rights & ~(upd[BIT_MOD] ? 3'b000 : 3'b010);

  always_comb begin
    d_fault = 1'b0;
    d_ptr   = 1'b0;
    d_leaf  = 1'b0;
    d_code  = '0;
    if (st == S_RD && mem_ack) begin
      if (mem_err) begin
        d_fault = 1'b1;
        d_code  = mk_code(lvl, FT_XLATE);
      end else begin
        unique case (mem_rdata[1:0])
          ET_INVALID: begin
            d_fault = 1'b1;
            d_code  = mk_code(lvl, FT_INVALID);
          end
          ET_PTR: begin
            if (lvl == 2'd3) begin
              d_fault = 1'b1;
              d_code  = mk_code(lvl, FT_XLATE);
            end else begin
              d_ptr = 1'b1;
            end
          end
          ET_LEAF: begin
            if (lvl == 2'd0) begin
              d_fault = 1'b1;
              d_code  = mk_code(lvl, FT_XLATE);
            end else if (p_ftype != FT_NONE && !(nofault && !sup)) begin
              d_fault = 1'b1;
              d_code  = mk_code(2'd0, p_ftype);
            end else begin
              d_leaf = 1'b1;
            end
          end
          default: begin
            d_fault = 1'b1;
            d_code  = mk_code(lvl, FT_XLATE);
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      lvl       <= '0;
      va        <= '0;
      kind      <= KIND_READ;
      sup       <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      rsp_size  <= '0;
      rsp_perm  <= '0;
      rsp_fcode <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (req_valid) begin
            va   <= req_vaddr;
            kind <= kind_e'(req_kind);
            sup  <= req_super;
            if (req_bypass) begin
              rsp_fault <= 1'b0;
              rsp_size  <= 2'd0;
              rsp_fcode <= '0;
              if (bootmode && kind_e'(req_kind) == KIND_FETCH) begin
                rsp_paddr <= prom_base | {{(PA_W-ROM_OFS_W){1'b0}}, req_vaddr[ROM_OFS_W-1:0]};
                rsp_perm  <= 3'b101;
              end else begin
                rsp_paddr <= {{(PA_W-VA_W){1'b0}}, req_vaddr};
                rsp_perm  <= 3'b111;
              end
              st <= S_RSP;
            end else begin
              mem_addr <= ctx_addr;
              mem_we   <= 1'b0;
              lvl      <= 2'd0;
              st       <= S_RD;
            end
          end
        end
        S_RD: begin
          if (d_fault) begin
            rsp_fault <= 1'b1;
            rsp_fcode <= d_code;
            rsp_paddr <= '0;
            rsp_size  <= '0;
            rsp_perm  <= '0;
            st        <= S_RSP;
          end else if (d_ptr) begin
            mem_addr <= nxt_ptr;
            lvl      <= lvl + 2'd1;
          end else if (d_leaf) begin
            rsp_fault <= 1'b0;
            rsp_fcode <= '0;
            rsp_paddr <= leaf_pa;
            rsp_size  <= 2'd3 - lvl;
            rsp_perm  <= fin_rights;
            if (upd != mem_rdata) begin
              mem_we    <= 1'b1;
              mem_wdata <= upd;
              st        <= S_WB;
            end else begin
              st <= S_RSP;
            end
          end
        end
        S_WB: begin
          if (mem_ack) begin
            mem_we <= 1'b0;
            st     <= S_RSP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  pgwalk_fsr u_fsr (
    .clk   (clk),
    .rst   (rst),
    .evt   (d_fault),
    .code  (d_code),
    .aidx  (aidx),
    .va    (va),
    .rd    (fsr_rd),
    .fsr_q (fsr_q),
    .far_q (far_q)
  );

  p_req_held_r12: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  p_idle_after_rsp_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> (req_ready && !rsp_valid));
  p_wb_sets_ref_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[BIT_REF]);
  p_write_right_clean_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_perm == 3'b000));
endmodule

// File: tb/pgwalk_top_tb_top.sv
module pgwalk_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_super = 0, req_bypass = 0;
  logic [31:0] req_vaddr = 0;
  logic [1:0]  req_kind = 0;
  logic        req_ready, rsp_valid, rsp_fault;
  logic [35:0] rsp_paddr;
  logic [1:0]  rsp_size;
  logic [2:0]  rsp_perm;
  logic [9:0]  rsp_fcode;
  logic        mem_req, mem_we;
  logic [35:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 0, mem_err = 0;
  logic [31:0] mem_rdata = 0;
  logic [31:0] ctx_ptr = 32'h0001_0000;
  logic [7:0]  ctx_num = 8'd3;
  logic        nofault = 0, bootmode = 0, fsr_rd = 0;
  logic [35:0] prom_base = 36'hF_F000_0000;
  logic [31:0] fsr_q, far_q;

  pgwalk_top #(.CTX_W(8)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind), .req_super(req_super), .req_bypass(req_bypass),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_size(rsp_size),
    .rsp_perm(rsp_perm), .rsp_fcode(rsp_fcode), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .ctx_ptr(ctx_ptr), .ctx_num(ctx_num), .nofault(nofault),
    .bootmode(bootmode), .prom_base(prom_base), .fsr_rd(fsr_rd), .fsr_q(fsr_q), .far_q(far_q)
  );

  int n_chk = 0, n_fail = 0, wr_cnt = 0;
  logic [31:0] mem [logic [35:0]];
  logic [35:0] err_addr = 36'h0_0060_0000;

  typedef struct packed {
    logic        f;
    logic [35:0] pa;
    logic [1:0]  sz;
    logic [2:0]  pm;
    logic [9:0]  fc;
  } exp_t;
  exp_t  sbq[$];
  string tagq[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: one word per ack, ack held one cycle
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end else if (mem_req) begin
      mem_ack = 1'b1;
      mem_err = (mem_addr == err_addr);
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        wr_cnt++;
      end
      mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'd0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rsp_valid) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R12 unexpected response", 64'd1, 64'd0);
      end else begin
        exp_t e;
        string t;
        e = sbq.pop_front();
        t = tagq.pop_front();
        chk(rsp_fault == e.f, {t, " fault"}, rsp_fault, e.f);
        if (e.f) begin
          chk(rsp_fcode == e.fc, {t, " fcode"}, rsp_fcode, e.fc);
        end else begin
          chk(rsp_paddr == e.pa, {t, " paddr"}, rsp_paddr, e.pa);
          chk(rsp_size == e.sz, {t, " size"}, rsp_size, e.sz);
          chk(rsp_perm == e.pm, {t, " perm"}, rsp_perm, e.pm);
        end
      end
    end
  end

  task automatic xlate(input logic [31:0] va, input logic [1:0] kd, input logic sp, input logic byp,
                       input logic f, input logic [35:0] pa, input logic [1:0] sz,
                       input logic [2:0] pm, input logic [9:0] fc, input string tag);
    exp_t e;
    e.f = f; e.pa = pa; e.sz = sz; e.pm = pm; e.fc = fc;
    sbq.push_back(e);
    tagq.push_back(tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_vaddr = va; req_kind = kd; req_super = sp; req_bypass = byp; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R12 busy after accept", req_ready, 0);
    while (sbq.size() != 0) @(negedge clk);
  endtask

  task automatic pulse_rd();
    @(negedge clk);
    fsr_rd = 1'b1;
    @(negedge clk);
    fsr_rd = 1'b0;
    @(negedge clk);
    chk(fsr_q == 32'd0, "R9 status cleared", fsr_q, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int wsave;
    // context table at 0x10_0000; ctx 3 -> L1 table at 0x20_0000 (R1)
    mem[36'h0_0010_000C] = 32'h0002_0001;
    mem[36'h0_0010_0010] = 32'h0000_0002;            // ctx 4: leaf at context level
    mem[36'h0_0020_0004] = 32'h4000_0006;            // L1 idx1: 16MB leaf, acc 1
    mem[36'h0_0020_0008] = 32'h0003_0001;            // L1 idx2: ptr -> 0x30_0000
    mem[36'h0_0020_0010] = 32'h0006_0001;            // L1 idx4: ptr -> 0x60_0000 (error)
    mem[36'h0_0020_0014] = 32'h5000_001A;            // L1 idx5: leaf acc 6
    mem[36'h0_0030_0014] = 32'h0123_406A;            // L2 idx5: 256KB leaf acc 2, R/M set
    mem[36'h0_0030_0018] = 32'h0005_0001;            // L2 idx6: ptr -> 0x50_0000
    mem[36'h0_0050_000C] = 32'h00AB_CD16;            // L3 idx3: 4KB leaf acc 5
    mem[36'h0_0050_0010] = 32'h0000_0001;            // L3 idx4: ptr at level 3

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R12 reset ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R12 reset no response", rsp_valid, 0);
    chk(mem_req == 1'b0, "R12 reset no memory request", mem_req, 0);
    chk(fsr_q == 32'd0, "R8 reset status", fsr_q, 0);

    // R1 R3 R6: level-1 leaf read, referenced flag written back; R7 no write right
    xlate(32'h0123_4567, 2'd0, 1'b0, 1'b0, 1'b0, 36'h4_0023_4567, 2'd2, 3'b100, 10'h0, "R3 L1 leaf read");
    chk(mem[36'h0_0020_0004] == 32'h4000_0026, "R6 referenced write-back", mem[36'h0_0020_0004], 32'h4000_0026);
    // R6 R7: write sets modified, write right granted
    xlate(32'h0100_0000, 2'd1, 1'b0, 1'b0, 1'b0, 36'h4_0000_0000, 2'd2, 3'b110, 10'h0, "R7 L1 leaf write");
    chk(mem[36'h0_0020_0004] == 32'h4000_0066, "R6 modified write-back", mem[36'h0_0020_0004], 32'h4000_0066);
    wsave = wr_cnt;
    xlate(32'h0100_0010, 2'd0, 1'b0, 1'b0, 1'b0, 36'h4_0000_0010, 2'd2, 3'b110, 10'h0, "R7 L1 reread");
    chk(wr_cnt == wsave, "R6 no write-back when unchanged", wr_cnt, wsave);

    // R2 R3: level-2 leaf fetch
    xlate(32'h0216_5ABC, 2'd2, 1'b0, 1'b0, 1'b0, 36'h0_1236_5ABC, 2'd1, 3'b101, 10'h0, "R2 L2 leaf fetch");
    // R3 R5: level-3 leaf supervisor write on field 5
    xlate(32'h0218_3123, 2'd1, 1'b1, 1'b0, 1'b0, 36'h0_0ABC_D123, 2'd0, 3'b110, 10'h0, "R5 L3 super write");
    chk(mem[36'h0_0050_000C] == 32'h00AB_CD76, "R6 L3 write-back", mem[36'h0_0050_000C], 32'h00AB_CD76);

    // R5 R8: user write on field 5 is a protection fault
    xlate(32'h0218_3123, 2'd1, 1'b0, 1'b0, 1'b1, 36'h0, 2'd0, 3'b000, 10'h008, "R5 user write prot");
    chk(fsr_q == 32'h0000_008A, "R8 status after first fault", fsr_q, 32'h8A);
    chk(far_q == 32'h0218_3123, "R8 fault address", far_q, 32'h0218_3123);
    pulse_rd();

    // R4 R8: invalid at level 1 then privilege fault gives overflow
    xlate(32'h0300_0000, 2'd0, 1'b0, 1'b0, 1'b1, 36'h0, 2'd0, 3'b000, 10'h104, "R4 invalid L1");
    chk(fsr_q == 32'h0000_0106, "R8 status invalid", fsr_q, 32'h106);
    xlate(32'h0500_0000, 2'd0, 1'b0, 1'b0, 1'b1, 36'h0, 2'd0, 3'b000, 10'h00C, "R5 user privilege");
    chk(fsr_q == 32'h0000_000F, "R8 overflow status", fsr_q, 32'hF);
    chk(far_q == 32'h0500_0000, "R8 second fault address", far_q, 32'h0500_0000);
    pulse_rd();

    // R4: remaining fault kinds
    xlate(32'h0218_4000, 2'd0, 1'b1, 1'b0, 1'b1, 36'h0, 2'd0, 3'b000, 10'h310, "R4 pointer at L3");
    xlate(32'h0218_5000, 2'd0, 1'b1, 1'b0, 1'b1, 36'h0, 2'd0, 3'b000, 10'h304, "R4 invalid L3");
    xlate(32'h0400_0000, 2'd0, 1'b1, 1'b0, 1'b1, 36'h0, 2'd0, 3'b000, 10'h210, "R4 memory error L2");
    @(negedge clk); ctx_num = 8'd4;
    xlate(32'h0100_0000, 2'd0, 1'b1, 1'b0, 1'b1, 36'h0, 2'd0, 3'b000, 10'h010, "R1 R4 leaf at context level");
    @(negedge clk); ctx_num = 8'd3;
    pulse_rd();

    // R10: no-fault lets user failure through, status untouched; supervisor still faults
    @(negedge clk); nofault = 1'b1;
    xlate(32'h0218_3123, 2'd1, 1'b0, 1'b0, 1'b0, 36'h0_0ABC_D123, 2'd0, 3'b100, 10'h0, "R10 suppressed user write");
    chk(fsr_q == 32'd0, "R10 status untouched", fsr_q, 0);
    xlate(32'h0300_0000, 2'd0, 1'b1, 1'b0, 1'b1, 36'h0, 2'd0, 3'b000, 10'h104, "R10 table fault kept");
    @(negedge clk); nofault = 1'b0;
    pulse_rd();

    // R11: bypass
    @(negedge clk); bootmode = 1'b1;
    wsave = wr_cnt;
    xlate(32'h1234_5678, 2'd2, 1'b1, 1'b1, 1'b0, 36'hF_F004_5678, 2'd0, 3'b101, 10'h0, "R11 boot fetch");
    xlate(32'h1234_5678, 2'd0, 1'b1, 1'b1, 1'b0, 36'h0_1234_5678, 2'd0, 3'b111, 10'h0, "R11 boot read");
    @(negedge clk); bootmode = 1'b0;
    xlate(32'h8765_4321, 2'd2, 1'b0, 1'b1, 1'b0, 36'h0_8765_4321, 2'd0, 3'b111, 10'h0, "R11 plain bypass fetch");
    chk(wr_cnt == wsave, "R11 no memory writes", wr_cnt, wsave);

    repeat (4) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule